// File: doc/BRIEF.md
# Voltage Regulator Fault Sequencer

This block is the digital protection and sequencing core of a multiphase buck regulator controller. It receives sampled 12-bit codes for the output voltage, the DAC target and the current-monitor level, together with flags for enable, supply power-on-reset completion, VID validity, the VID off code, soft-start completion, an average-current comparator and a single-cycle switching tick. From these it decides, every cycle, whether the PWM stages may run normally, must pull their outputs low, or must release them to high impedance. It also produces the power-good output and a soft-start request for the ramp generator.

Overvoltage is latched. The first excursion pulls every phase low at once. The phases then float once the output has fallen far enough, and they are pulled low again if the excursion returns. Only an enable cycle or a supply reset ends this state. Overcurrent starts a hiccup sequence instead: every phase floats, a fixed number of switching ticks pass, and then a new soft-start is requested for as long as the controller stays enabled. Power-good follows a successful soft-start after a programmable number of ticks, and it drops as soon as any fault or disable condition appears.

Top module: `vrf_seq`

## Requirements
- R1: Until a valid VID has been registered since the last enable or supply reset, an overvoltage is detected when the output code is strictly greater than 1273 (1 mV per LSB).
- R2: Once a valid VID has been registered, an overvoltage is detected when the output code is strictly greater than the DAC code plus 175.
- R3: In every cycle with an overvoltage detected after power-on-reset, enabled or not, each 2-bit phase field of `phase_o` (phase i at bits 2i+1:2i) reads 01 (force low) in that same cycle.
- R4: After an overvoltage, the phases stay at 01 until a clock edge sees the output code below the DAC code plus 75. From then on they read 10 (high impedance), and they return to 01 in the same cycle if an overvoltage recurs.
- R5: An overvoltage is latched. While it is latched, `ss_req_o` and `pgood_o` stay low and no phase reads 00. A VID off code or a DAC change does not clear it. A rising edge of `en_i`, or a low `por_ok_i`, clears it, and the next edge then starts a soft-start.
- R6: `pgood_o` is low in any cycle in which the output code is below the DAC code shifted right by one.
- R7: An overcurrent (`imon_i` strictly greater than 1110, or `iavg_ovr_i` high) sets every phase to 10 in the same cycle, unless an overvoltage forces 01.
- R8: After an overcurrent trip, `ss_req_o` rises again exactly HICCUP_TICKS switching ticks after the tripping edge if the controller is still enabled.
- R9: After the edge that samples `ss_done_i`, `ss_req_o` falls, and `pgood_o` rises after PG_DELAY_TICKS further ticks.
- R10: A low `en_i`, a low `por_ok_i` or a high `vid_off_i` drops `pgood_o` in the same cycle. At the next edge the block goes idle with `ss_req_o` low and all phases at 10, and any partly elapsed hiccup wait is discarded.
- R11: When overvoltage and overcurrent are present in the same cycle, the phases read 01.
- R12: During soft-start, the power-good delay and normal operation without a fault, every phase reads 00 (pass-through).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Controller enable (combined enables) |
| por_ok_i | input | 1 | Supply power-on-reset complete |
| vid_valid_i | input | 1 | VID code recognised as valid |
| vid_off_i | input | 1 | VID off code present |
| ss_done_i | input | 1 | Soft-start ramp finished |
| sw_tick_i | input | 1 | One-cycle pulse per switching period |
| iavg_ovr_i | input | 1 | Average current above its reference |
| vout_i | input | VW | Sensed output voltage code, 1 mV/LSB |
| dac_i | input | VW | DAC target code, 1 mV/LSB |
| imon_i | input | VW | Current-monitor voltage code, 1 mV/LSB |
| phase_o | output | 2*NPH | Per-phase override: 00 pass, 01 low, 10 high-Z |
| pgood_o | output | 1 | Power-good |
| ss_req_o | output | 1 | Soft-start request |

## Verification
A stuck or mis-set overvoltage latch shows at once at the ports. Either the phases read 10 where 00 is expected, or `ss_req_o` fails to come back two edges after an enable cycle. A mis-set force-low flag shows as 01 persisting past the release level or missing on a recurrence within one cycle. A counter that is off by one, or that is not cleared, moves the return of `ss_req_o` or the rise of `pgood_o` by one or more ticks, so those edges are sampled at the exact expected tick and one tick earlier. A wrong threshold select shows as a one-code error at 1273/1274 or at DAC+175/176.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   typedef enum logic [1:0] {
      PH_PASS = 2'b00,
      PH_LOW  = 2'b01,
      PH_HIZ  = 2'b10
   } ph_e;

   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_SOFT = 3'd1,
      ST_PGW  = 3'd2,
      ST_RUN  = 3'd3,
      ST_OCW  = 3'd4
   } st_e;
endpackage

// File: rtl/vrf_thresh.sv
module vrf_thresh #(
   parameter int VW       = 12,
   parameter int OV_FIX   = 1273,
   parameter int OV_OFS   = 175,
   parameter int OV_REL   = 75,
   parameter int IMON_LIM = 1110
) (
   input  logic          por_ok,
   input  logic          vid_seen,
   input  logic          iavg_ovr,
   input  logic [VW-1:0] vout,
   input  logic [VW-1:0] dac,
   input  logic [VW-1:0] imon,
   output logic          ov_trip,
   output logic          ov_rel,
   output logic          uv,
   output logic          oc_trip
);
   localparam int EW = VW + 1;

   if (OV_FIX >= (1 << VW)) begin : g_bad_fix
      $error("vrf_thresh: OV_FIX does not fit in VW bits");
   end
   if (IMON_LIM >= (1 << VW)) begin : g_bad_imon
      $error("vrf_thresh: IMON_LIM does not fit in VW bits");
   end

   logic [EW-1:0] vout_x, dac_x, ov_lvl, rel_lvl;

   always_comb begin
      vout_x  = {1'b0, vout};
      dac_x   = {1'b0, dac};
      ov_lvl  = vid_seen ? (dac_x + EW'(OV_OFS)) : EW'(OV_FIX);
      rel_lvl = dac_x + EW'(OV_REL);
      ov_trip = por_ok && (vout_x > ov_lvl);
      ov_rel  = vout_x < rel_lvl;
      uv      = vout < (dac >> 1);
      oc_trip = iavg_ovr || (imon > VW'(IMON_LIM));
   end
endmodule

// File: rtl/vrf_ov_latch.sv
module vrf_ov_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic por_ok,
   input  logic en,
   input  logic ov_trip,
   input  logic ov_rel,
   output logic lat,
   output logic low
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         lat  <= 1'b0;
         low  <= 1'b0;
      end else begin
         en_q <= en;
         if (!por_ok) begin
            lat <= 1'b0;
            low <= 1'b0;
         end else if (ov_trip) begin
            lat <= 1'b1;
            low <= 1'b1;
         end else if (en && !en_q) begin
            lat <= 1'b0;
            low <= 1'b0;
         end else if (ov_rel) begin
            low <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vrf_tick_cnt.sv
module vrf_tick_cnt #(
   parameter int CW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   input  logic [CW-1:0] lim,
   output logic          done
);
   logic [CW-1:0] cnt;

   assign done = tick && (cnt == (lim - CW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= done ? '0 : cnt + CW'(1);
      end
   end
endmodule

// File: rtl/vrf_seq.sv
module vrf_seq #(
   parameter int NPH          = 4,
   parameter int VW           = 12,
   parameter int HICCUP_TICKS = 4096,
   parameter int PG_DELAY_TICKS = 8,
   parameter int OV_FIX       = 1273,
   parameter int OV_OFS       = 175,
   parameter int OV_REL       = 75,
   parameter int IMON_LIM     = 1110
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             por_ok_i,
   input  logic             vid_valid_i,
   input  logic             vid_off_i,
   input  logic             ss_done_i,
   input  logic             sw_tick_i,
   input  logic             iavg_ovr_i,
   input  logic [VW-1:0]    vout_i,
   input  logic [VW-1:0]    dac_i,
   input  logic [VW-1:0]    imon_i,
   output logic [2*NPH-1:0] phase_o,
   output logic             pgood_o,
   output logic             ss_req_o
);
   import vrf_pkg::*;

   localparam int MAXL = (HICCUP_TICKS > PG_DELAY_TICKS) ? HICCUP_TICKS : PG_DELAY_TICKS;
   localparam int CW   = $clog2(MAXL + 1);

   if (NPH < 1) begin : g_bad_nph
      $error("vrf_seq: NPH must be at least 1");
   end
   if (VW < 12) begin : g_bad_vw
      $error("vrf_seq: VW must hold the fixed thresholds");
   end
   if (HICCUP_TICKS < 2) begin : g_bad_hic
      $error("vrf_seq: HICCUP_TICKS must be at least 2");
   end

   logic ov_trip, ov_rel, uv, oc_trip;
   logic ov_lat, ov_low;
   logic vid_seen;
   logic dis;
   logic cnt_clr, cnt_done;
   logic [CW-1:0] cnt_lim;
   st_e  st, st_nxt, soft_exit;
   ph_e  ph_code;

   vrf_thresh #(
      .VW(VW), .OV_FIX(OV_FIX), .OV_OFS(OV_OFS), .OV_REL(OV_REL), .IMON_LIM(IMON_LIM)
   ) i_thr (
      .por_ok(por_ok_i), .vid_seen(vid_seen), .iavg_ovr(iavg_ovr_i),
      .vout(vout_i), .dac(dac_i), .imon(imon_i),
      .ov_trip(ov_trip), .ov_rel(ov_rel), .uv(uv), .oc_trip(oc_trip)
   );

   vrf_ov_latch i_ovl (
      .clk(clk), .rst_n(rst_n), .por_ok(por_ok_i), .en(en_i),
      .ov_trip(ov_trip), .ov_rel(ov_rel), .lat(ov_lat), .low(ov_low)
   );

   vrf_tick_cnt #(.CW(CW)) i_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(sw_tick_i),
      .lim(cnt_lim), .done(cnt_done)
   );

   // Threshold select: a valid VID seen since the last enable/supply reset.
   always_ff @(posedge clk) begin
      if (!rst_n || !por_ok_i || !en_i || vid_off_i) begin
         vid_seen <= 1'b0;
      end else if (vid_valid_i) begin
         vid_seen <= 1'b1;
      end
   end

   // A zero power-good delay skips the waiting state entirely.
   if (PG_DELAY_TICKS == 0) begin : g_pg_skip
      assign soft_exit = ST_RUN;
   end else begin : g_pg_wait
      assign soft_exit = ST_PGW;
   end

   assign dis     = !en_i || !por_ok_i || vid_off_i || ov_lat || ov_trip;
   assign cnt_lim = (st == ST_OCW) ? CW'(HICCUP_TICKS) : CW'(PG_DELAY_TICKS);
   assign cnt_clr = (st_nxt != st) || ((st != ST_OCW) && (st != ST_PGW));

   always_comb begin
      st_nxt = st;
      unique case (st)
         ST_OFF:  st_nxt = ST_SOFT;
         ST_SOFT: begin
            if (oc_trip)        st_nxt = ST_OCW;
            else if (ss_done_i) st_nxt = soft_exit;
         end
         ST_PGW: begin
            if (oc_trip)       st_nxt = ST_OCW;
            else if (cnt_done) st_nxt = ST_RUN;
         end
         ST_RUN:  if (oc_trip)  st_nxt = ST_OCW;
         ST_OCW:  if (cnt_done) st_nxt = ST_SOFT;
         default: st_nxt = ST_OFF;
      endcase
      if (dis) st_nxt = ST_OFF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= st_nxt;
   end

   always_comb begin
      if (ov_trip || (ov_lat && ov_low))
         ph_code = PH_LOW;
      else if (ov_lat || oc_trip || (st == ST_OFF) || (st == ST_OCW))
         ph_code = PH_HIZ;
      else
         ph_code = PH_PASS;
   end

   for (genvar g = 0; g < NPH; g++) begin : g_phase
      assign phase_o[2*g +: 2] = ph_code;
   end

   assign pgood_o  = (st == ST_RUN) && !uv && !dis && !oc_trip;
   assign ss_req_o = (st == ST_SOFT);
endmodule

// File: rtl/vrf_seq_chk.sv
module vrf_seq_chk #(
   parameter int NPH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en_i,
   input logic             por_ok_i,
   input logic [2*NPH-1:0] phase_o,
   input logic             pgood_o,
   input logic             ss_req_o,
   input logic             ov_trip,
   input logic             oc_trip,
   input logic             uv,
   input logic             ov_lat,
   input logic             ov_low
);
   localparam logic [2*NPH-1:0] ALL_LOW = {NPH{2'b01}};
   localparam logic [2*NPH-1:0] ALL_HIZ = {NPH{2'b10}};

   p_ov_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ov_trip |-> phase_o == ALL_LOW);

   p_rel_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_lat && !ov_low && !ov_trip) |-> phase_o == ALL_HIZ);

   p_lat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_lat && por_ok_i && !en_i) |=> ov_lat);

   p_lat_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ov_lat |-> (!ss_req_o && !pgood_o));

   p_pg_no_uv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pgood_o |-> !uv);

   p_oc_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (oc_trip && !ov_trip && !(ov_lat && ov_low)) |-> phase_o == ALL_HIZ);

   p_dis_pg_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || !por_ok_i) |-> !pgood_o);
endmodule

bind vrf_seq vrf_seq_chk #(.NPH(NPH)) i_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .por_ok_i(por_ok_i),
   .phase_o(phase_o), .pgood_o(pgood_o), .ss_req_o(ss_req_o),
   .ov_trip(ov_trip), .oc_trip(oc_trip), .uv(uv),
   .ov_lat(ov_lat), .ov_low(ov_low)
);

// File: tb/test_vrf_seq.sv
module test_vrf_seq;
   localparam int CLK_NS = 10;
   localparam int NPH    = 4;
   localparam int VW     = 12;
   localparam int HIC    = 4096;
   localparam int PGD    = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_i = 1'b0, por_ok_i = 1'b0, vid_valid_i = 1'b0, vid_off_i = 1'b0;
   logic ss_done_i = 1'b0, sw_tick_i = 1'b0, iavg_ovr_i = 1'b0;
   logic [VW-1:0] vout_i = '0, dac_i = '0, imon_i = '0;
   logic [2*NPH-1:0] phase_o;
   logic pgood_o, ss_req_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_NS/2) clk = ~clk;

   vrf_seq #(.NPH(NPH), .VW(VW), .HICCUP_TICKS(HIC), .PG_DELAY_TICKS(PGD)) i_vrf_seq (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .por_ok_i(por_ok_i),
      .vid_valid_i(vid_valid_i), .vid_off_i(vid_off_i), .ss_done_i(ss_done_i),
      .sw_tick_i(sw_tick_i), .iavg_ovr_i(iavg_ovr_i), .vout_i(vout_i),
      .dac_i(dac_i), .imon_i(imon_i), .phase_o(phase_o), .pgood_o(pgood_o),
      .ss_req_o(ss_req_o)
   );

   function automatic logic [2*NPH-1:0] all_ph(input logic [1:0] c);
      return {NPH{c}};
   endfunction

   function automatic logic [1:0] exp_code(input logic trip, input logic lat,
                                           input logic low, input logic [1:0] base);
      if (trip || (lat && low)) return 2'b01;
      if (lat) return 2'b10;
      return base;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic lat, low, trip;
      void'($urandom(32'd4711));
      step(3);
      rst_n = 1'b1;
      #1;
      // R10: idle after reset
      chk("R10 reset phase", phase_o, all_ph(2'b10));
      chk("R10 reset pgood", pgood_o, 0);
      chk("R10 reset ss_req", ss_req_o, 0);

      por_ok_i = 1; en_i = 1; vid_valid_i = 1; dac_i = 1200; vout_i = 1200; sw_tick_i = 1;
      step(1);
      chk("R12 soft ss_req", ss_req_o, 1);
      chk("R12 soft pass", phase_o, all_ph(2'b00));

      ss_done_i = 1;
      step(1);
      ss_done_i = 0;
      #1;
      chk("R9 ss_req falls", ss_req_o, 0);
      chk("R12 pg wait pass", phase_o, all_ph(2'b00));
      step(PGD - 1);
      chk("R9 pgood early", pgood_o, 0);
      step(1);
      chk("R9 pgood rises", pgood_o, 1);

      vout_i = 599; #1;
      chk("R6 uv pgood", pgood_o, 0);
      vout_i = 600; #1;
      chk("R6 at half pgood", pgood_o, 1);

      vid_off_i = 1; #1;
      chk("R10 vid off pgood", pgood_o, 0);
      step(1);
      chk("R10 vid off phase", phase_o, all_ph(2'b10));
      chk("R10 vid off ss_req", ss_req_o, 0);
      vid_off_i = 0;
      step(1);
      chk("R10 restart ss_req", ss_req_o, 1);

      // R7 / R8: current-monitor trip and hiccup
      imon_i = 1111; #1;
      chk("R7 imon hiz", phase_o, all_ph(2'b10));
      step(1);
      imon_i = 0; #1;
      chk("R8 wait ss_req", ss_req_o, 0);
      step(HIC - 1);
      chk("R8 one tick early", ss_req_o, 0);
      chk("R8 hiz in wait", phase_o, all_ph(2'b10));
      step(1);
      chk("R8 retry ss_req", ss_req_o, 1);

      iavg_ovr_i = 1; #1;
      chk("R7 iavg hiz", phase_o, all_ph(2'b10));
      step(1);
      iavg_ovr_i = 0;
      step(100);
      en_i = 0;
      step(1);
      chk("R10 disable ss_req", ss_req_o, 0);
      chk("R10 disable phase", phase_o, all_ph(2'b10));
      en_i = 1;
      step(1);
      chk("R10 re-enable ss_req", ss_req_o, 1);
      imon_i = 1111;
      step(1);
      imon_i = 0;
      step(HIC - 1);
      chk("R10 counter cleared early", ss_req_o, 0);
      step(1);
      chk("R10 counter cleared retry", ss_req_o, 1);

      // R2 threshold with VID seen, then latch behaviour
      vout_i = 1375; #1;
      chk("R2 at dac+175", phase_o, all_ph(2'b00));
      vout_i = 1376; #1;
      chk("R2 above dac+175", phase_o, all_ph(2'b01));
      imon_i = 1111; #1;
      chk("R11 ov over oc", phase_o, all_ph(2'b01));
      step(1);
      imon_i = 0; vout_i = 1300; #1;
      chk("R4 held low", phase_o, all_ph(2'b01));
      step(1);
      chk("R4 held low above release", phase_o, all_ph(2'b01));
      vout_i = 1270;
      step(1);
      chk("R4 release hiz", phase_o, all_ph(2'b10));
      vout_i = 1400; #1;
      chk("R4 recur low", phase_o, all_ph(2'b01));
      vout_i = 900;
      step(1);
      chk("R4 release again", phase_o, all_ph(2'b10));
      vid_off_i = 1;
      step(1);
      vid_off_i = 0; dac_i = 1000;
      step(1);
      chk("R5 vid cycle keeps latch phase", phase_o, all_ph(2'b10));
      chk("R5 vid cycle keeps latch ss_req", ss_req_o, 0);
      en_i = 0;
      step(1);
      en_i = 1;
      step(1);
      chk("R5 clearing edge", ss_req_o, 0);
      step(1);
      chk("R5 restart ss_req", ss_req_o, 1);
      chk("R5 restart pass", phase_o, all_ph(2'b00));

      // R1: fixed threshold before VID
      por_ok_i = 0; vid_valid_i = 0;
      step(1);
      por_ok_i = 1;
      step(1);
      dac_i = 400; vout_i = 1273; #1;
      chk("R1 at fixed level", phase_o, all_ph(2'b00));
      vout_i = 1274; #1;
      chk("R1 above fixed level", phase_o, all_ph(2'b01));

      // R3 random: disabled, fixed threshold
      por_ok_i = 0;
      step(1);
      por_ok_i = 1; en_i = 0; vout_i = 1000;
      step(1);
      lat = 0; low = 0;
      for (int k = 0; k < 300; k++) begin
         dac_i  = VW'(900 + $urandom % 400);
         vout_i = VW'(1100 + $urandom % 350);
         #1;
         trip = (vout_i > 1273);
         chk("R3 random disabled", phase_o, all_ph(exp_code(trip, lat, low, 2'b10)));
         step(1);
         if (trip) begin lat = 1; low = 1; end
         else if (int'(vout_i) < int'(dac_i) + 75) low = 0;
      end

      // R2/R4 random: enabled, VID-relative threshold
      por_ok_i = 0;
      step(1);
      por_ok_i = 1; en_i = 1; vid_valid_i = 1; dac_i = 1000; vout_i = 1000;
      step(2);
      lat = 0; low = 0;
      for (int k = 0; k < 300; k++) begin
         dac_i  = VW'(900 + $urandom % 400);
         vout_i = VW'(int'(dac_i) - 100 + int'($urandom % 400));
         #1;
         trip = (int'(vout_i) > int'(dac_i) + 175);
         chk("R4 random enabled", phase_o, all_ph(exp_code(trip, lat, low, 2'b00)));
         step(1);
         if (trip) begin lat = 1; low = 1; end
         else if (int'(vout_i) < int'(dac_i) + 75) low = 0;
      end

      finish_run();
   end
endmodule